// File: doc/BRIEF.md
# Low-Address Protection and Prefix Mapping Unit

This unit screens every storage access before the translated address reaches memory. It tests the logical address against two small protected windows at the bottom of storage, applying the protection only when the control enable bit is set and the address-space mode allows it. It turns the real address into an absolute address by swapping the first 8 KiB of storage with the 8 KiB area named by the per-CPU prefix register. It also composes the translation-exception code that software reads when an access is refused.

Table walking is done elsewhere. When translation is on, the translator supplies the real page and two permission bits, and this unit turns them into protection verdicts. When translation is off, the logical address is the real address and the permission bits are ignored. Each accepted request produces one registered response one cycle later. The response carries the absolute address, the access flags, the exception code and an exception identifier. Requests and responses use a valid/ready handshake.

Top module: `lap_prefix_unit`

## Requirements
- R1: A store is refused with exception identifier 1 (protection) when low-address protection is active and the logical address lies in 0..511 or 4096..4607. Bit 7 (0x80) is then set in the exception code. A store at 512..4095, at 4608 or above, or any load or fetch in the windows, gets no such refusal.
- R2: Low-address protection is active only when `lap_en` is 1. With `dat_on` 0 it is always active. With `dat_on` 1 it is active only when the private bit of the mode's space descriptor is 0: mode 0 uses `priv_primary`, mode 2 uses `priv_secondary`, mode 3 uses `priv_home`, and mode 1 has no descriptor, so protection stays active.
- R3: `rsp_wr_inv` is 1 exactly when protection is active and the page-aligned logical address lies in a protected window. This holds for every access type, including accesses that are allowed.
- R4: The real address maps to the absolute address as follows, with P = `pfx_base` shifted left by 13. A real address below 0x2000 becomes that address plus P. A real address in [P, P+0x2000) becomes that address minus P. Any other real address is unchanged. The real address is the logical address when `dat_on` is 0. When `dat_on` is 1 it is `xlat_page` joined with the low 12 bits of the logical address.
- R5: Without an exception, the code is the logical address with its low 12 bits cleared, ORed with the mode in bits 1:0. It is also ORed with 0x400 for a store (access 1), or with 0x800 for any other access code (0 load, 2 fetch, 3 treated as a load).
- R6: With `dat_on` 1, a store with `xlat_wr_ok` 0 is refused as protection with 0x04 added to the code. A fetch with `xlat_ex_ok` 0 is refused as protection with 0x84 added. A low-address refusal (R1) takes priority and adds only 0x80. With `dat_on` 0 both permission bits have no effect.
- R7: If no protection refusal applies and the absolute page number is MEM_PAGES or more, the identifier is 2 (addressing) and the code is forced to 0. Otherwise the identifier is 0.
- R8: `rsp_rd` is always 1. `rsp_wr` is 0 only when `dat_on` is 1 and `xlat_wr_ok` is 0. `rsp_ex` is 0 only when `dat_on` is 1 and `xlat_ex_ok` is 0.
- R9: A request accepted on a clock edge (`req_valid` and `req_ready` both 1) gives `rsp_valid` 1 after that edge. While `rsp_ready` is 0 the response stays valid and unchanged, and `req_ready` is 0.
- R10: During and after reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_addr | input | AW | Logical address |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| req_mode | input | 2 | Address-space mode: 0 primary, 1 access-register, 2 secondary, 3 home |
| lap_en | input | 1 | Control-register low-address protection enable |
| dat_on | input | 1 | Translation mode on |
| priv_primary | input | 1 | Private bit of the primary space descriptor |
| priv_secondary | input | 1 | Private bit of the secondary space descriptor |
| priv_home | input | 1 | Private bit of the home space descriptor |
| xlat_page | input | AW-PAGE_BITS | Real page number from the translator |
| xlat_wr_ok | input | 1 | Translator allows stores |
| xlat_ex_ok | input | 1 | Translator allows fetches |
| pfx_base | input | AW-AREA_BITS | Prefix register, 8 KiB aligned part |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_abs | output | AW | Absolute address |
| rsp_rd | output | 1 | Read allowed flag |
| rsp_wr | output | 1 | Write allowed flag |
| rsp_ex | output | 1 | Execute allowed flag |
| rsp_wr_inv | output | 1 | Entry must not be reused for writes |
| rsp_code | output | AW | Translation-exception code |
| rsp_exc | output | 2 | Exception: 0 none, 1 protection, 2 addressing |

## Verification
The bench builds the unit with a 32-bit address, 4 KiB pages and an 8 KiB prefix area, and cuts the memory to MEM_PAGES = 256 (1 MiB). With that smaller memory, addressing exceptions are reached with short addresses, including prefix values whose swapped area lies beyond the end of storage. A driver pushes the values expected from an independent model into a scoreboard, and a monitor compares each response as it is handed over. One sequence holds `rsp_ready` low to check that the response is held.

// File: rtl/lapu_pkg.sv
`timescale 1ns/1ps
package lapu_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    MODE_PRI  = 2'd0,
    MODE_AREG = 2'd1,
    MODE_SEC  = 2'd2,
    MODE_HOME = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_PROT = 2'd1,
    EXC_ADDR = 2'd2,
    EXC_RSVD = 2'd3
  } exc_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
    logic wr_inv;
  } perm_t;

  // Bit positions inside the exception code; consumers decode these.
  localparam int CB_NONSTORE = 11;
  localparam int CB_STORE    = 10;
  localparam int CB_LOWPROT  = 7;
  localparam int CB_DATPROT  = 2;

endpackage

// File: rtl/lapu_lowprot.sv
`timescale 1ns/1ps
module lapu_lowprot
  import lapu_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int WINDOWS   = 2,
  parameter int SPAN      = 512
) (
  input  logic [AW-1:0] addr,
  input  logic          en,
  input  logic          dat_on,
  input  mode_e         mode,
  input  logic          priv_primary,
  input  logic          priv_secondary,
  input  logic          priv_home,
  output logic          active,
  output logic          addr_hit,
  output logic          page_hit
);

  localparam logic [AW-1:0] SPAN_W = AW'(SPAN);

  logic [AW-1:0]      page_addr;
  logic [WINDOWS-1:0] addr_in;
  logic [WINDOWS-1:0] page_in;
  logic               priv_sel;

  assign page_addr = {addr[AW-1:PAGE_BITS], {PAGE_BITS{1'b0}}};

  // One window per leading page; offset compare wraps below the base.
  for (genvar w = 0; w < WINDOWS; w++) begin : g_win
    localparam logic [AW-1:0] BASE = AW'(w) << PAGE_BITS;
    logic [AW-1:0] addr_off;
    logic [AW-1:0] page_off;
    assign addr_off   = addr - BASE;
    assign page_off   = page_addr - BASE;
    assign addr_in[w] = addr_off < SPAN_W;
    assign page_in[w] = page_off < SPAN_W;
  end

  always_comb begin
    priv_sel = 1'b0;
    case (mode)
      MODE_PRI:  priv_sel = priv_primary;
      MODE_SEC:  priv_sel = priv_secondary;
      MODE_HOME: priv_sel = priv_home;
      default:   priv_sel = 1'b0;
    endcase
  end

  assign active   = en && (!dat_on || !priv_sel);
  assign addr_hit = |addr_in;
  assign page_hit = |page_in;

endmodule

// File: rtl/lapu_prefix.sv
`timescale 1ns/1ps
module lapu_prefix #(
  parameter int AW        = 32,
  parameter int AREA_BITS = 13
) (
  input  logic [AW-1:0]           real_addr,
  input  logic [AW-AREA_BITS-1:0] pfx_base,
  output logic [AW-1:0]           abs_addr
);

  localparam int HW = AW - AREA_BITS;

  logic [HW-1:0]        real_hi;
  logic [AREA_BITS-1:0] real_lo;
  logic                 in_low;
  logic                 in_pfx;

  assign real_hi = real_addr[AW-1:AREA_BITS];
  assign real_lo = real_addr[AREA_BITS-1:0];
  assign in_low  = (real_hi == '0);
  assign in_pfx  = (real_hi == pfx_base);

  // Area-aligned swap: adding or subtracting the prefix only touches the
  // upper field, so both directions reduce to a field substitution.
  always_comb begin
    abs_addr = real_addr;
    if (in_low) begin
      abs_addr = {pfx_base, real_lo};
    end else if (in_pfx) begin
      abs_addr = {{HW{1'b0}}, real_lo};
    end
  end

endmodule

// File: rtl/lapu_verdict.sv
`timescale 1ns/1ps
module lapu_verdict
  import lapu_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int MEM_PAGES = 65536
) (
  input  logic [AW-1:0] vaddr,
  input  acc_e          acc,
  input  mode_e         mode,
  input  logic          dat_on,
  input  logic          wr_ok,
  input  logic          ex_ok,
  input  logic          lp_active,
  input  logic          lp_addr_hit,
  input  logic          lp_page_hit,
  input  logic [AW-1:0] abs_addr,
  output exc_e          exc,
  output logic [AW-1:0] code,
  output perm_t         perm
);

  localparam int PW = AW - PAGE_BITS;
  localparam logic [PW:0]   MEM_LIM  = (PW+1)'(MEM_PAGES);
  localparam logic [AW-1:0] LAP_BIT  = AW'(1) << CB_LOWPROT;
  localparam logic [AW-1:0] DAT_BIT  = AW'(1) << CB_DATPROT;

  logic          is_store;
  logic          is_fetch;
  logic          mem_ok;
  logic [AW-1:0] base_code;

  assign is_store = (acc == ACC_STORE);
  assign is_fetch = (acc == ACC_FETCH);
  assign mem_ok   = {1'b0, abs_addr[AW-1:PAGE_BITS]} < MEM_LIM;

  always_comb begin
    base_code = '0;
    base_code[AW-1:PAGE_BITS] = vaddr[AW-1:PAGE_BITS];
    base_code[1:0] = mode;
    if (is_store) begin
      base_code[CB_STORE] = 1'b1;
    end else begin
      base_code[CB_NONSTORE] = 1'b1;
    end
  end

  always_comb begin
    perm.rd     = 1'b1;
    perm.wr     = !(dat_on && !wr_ok);
    perm.ex     = !(dat_on && !ex_ok);
    perm.wr_inv = lp_active && lp_page_hit;
  end

  // Priority: low-address store, translated store, translated fetch, range.
  always_comb begin
    exc  = EXC_NONE;
    code = base_code;
    if (lp_active && lp_addr_hit && is_store) begin
      exc  = EXC_PROT;
      code = base_code | LAP_BIT;
    end else if (dat_on && is_store && !wr_ok) begin
      exc  = EXC_PROT;
      code = base_code | DAT_BIT;
    end else if (dat_on && is_fetch && !ex_ok) begin
      exc  = EXC_PROT;
      code = base_code | LAP_BIT | DAT_BIT;
    end else if (!mem_ok) begin
      exc  = EXC_ADDR;
      code = '0;
    end
  end

endmodule

// File: rtl/lap_prefix_unit.sv
`timescale 1ns/1ps
module lap_prefix_unit
  import lapu_pkg::*;
#(
  parameter int AW          = 32,
  parameter int PAGE_BITS   = 12,
  parameter int AREA_BITS   = 13,
  parameter int MEM_PAGES   = 65536,
  parameter int LOW_WINDOWS = 2,
  parameter int LOW_SPAN    = 512
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [AW-1:0]           req_addr,
  input  logic [1:0]              req_acc,
  input  logic [1:0]              req_mode,
  input  logic                    lap_en,
  input  logic                    dat_on,
  input  logic                    priv_primary,
  input  logic                    priv_secondary,
  input  logic                    priv_home,
  input  logic [AW-PAGE_BITS-1:0] xlat_page,
  input  logic                    xlat_wr_ok,
  input  logic                    xlat_ex_ok,
  input  logic [AW-AREA_BITS-1:0] pfx_base,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [AW-1:0]           rsp_abs,
  output logic                    rsp_rd,
  output logic                    rsp_wr,
  output logic                    rsp_ex,
  output logic                    rsp_wr_inv,
  output logic [AW-1:0]           rsp_code,
  output logic [1:0]              rsp_exc
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_q = rst_pipe[1];

  acc_e  acc;
  mode_e mode;
  assign acc  = acc_e'(req_acc);
  assign mode = mode_e'(req_mode);

  // Real address selection.
  logic [AW-1:0] real_addr;
  assign real_addr = dat_on ? {xlat_page, req_addr[PAGE_BITS-1:0]} : req_addr;

  logic lp_active, lp_addr_hit, lp_page_hit;

  lapu_lowprot #(
    .AW(AW), .PAGE_BITS(PAGE_BITS), .WINDOWS(LOW_WINDOWS), .SPAN(LOW_SPAN)
  ) i_lowprot (
    .addr           (req_addr),
    .en             (lap_en),
    .dat_on         (dat_on),
    .mode           (mode),
    .priv_primary   (priv_primary),
    .priv_secondary (priv_secondary),
    .priv_home      (priv_home),
    .active         (lp_active),
    .addr_hit       (lp_addr_hit),
    .page_hit       (lp_page_hit)
  );

  logic [AW-1:0] abs_addr;

  lapu_prefix #(.AW(AW), .AREA_BITS(AREA_BITS)) i_prefix (
    .real_addr (real_addr),
    .pfx_base  (pfx_base),
    .abs_addr  (abs_addr)
  );

  exc_e          exc_c;
  logic [AW-1:0] code_c;
  perm_t         perm_c;

  lapu_verdict #(.AW(AW), .PAGE_BITS(PAGE_BITS), .MEM_PAGES(MEM_PAGES)) i_verdict (
    .vaddr       (req_addr),
    .acc         (acc),
    .mode        (mode),
    .dat_on      (dat_on),
    .wr_ok       (xlat_wr_ok),
    .ex_ok       (xlat_ex_ok),
    .lp_active   (lp_active),
    .lp_addr_hit (lp_addr_hit),
    .lp_page_hit (lp_page_hit),
    .abs_addr    (abs_addr),
    .exc         (exc_c),
    .code        (code_c),
    .perm        (perm_c)
  );

  // Handshake next-state.
  logic take;
  logic valid_d;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_comb begin
    valid_d = rsp_valid;
    if (take) begin
      valid_d = 1'b1;
    end else if (rsp_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
    end
  end

  // Result registers, clock-enabled by acceptance, no reset.
  perm_t perm_q;

  always_ff @(posedge clk) begin
    if (take) begin
      rsp_abs  <= abs_addr;
      rsp_code <= code_c;
      rsp_exc  <= exc_c;
      perm_q   <= perm_c;
    end
  end

  assign rsp_rd     = perm_q.rd;
  assign rsp_wr     = perm_q.wr;
  assign rsp_ex     = perm_q.ex;
  assign rsp_wr_inv = perm_q.wr_inv;

  // Assertions.
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_q)
    take |=> rsp_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code) && $stable(rsp_abs)
                                && $stable(rsp_exc));

  p_addr_zero_r7: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_valid && (rsp_exc == EXC_ADDR) |-> (rsp_code == '0));

  p_lap_inv_r3: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_valid && (rsp_exc == EXC_PROT) && rsp_code[CB_LOWPROT] && !rsp_code[CB_DATPROT]
      |-> rsp_wr_inv);

  p_store_bit_r5: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_valid && (rsp_exc != EXC_ADDR) |-> (rsp_code[CB_STORE] != rsp_code[CB_NONSTORE]));

  p_dat_perm_r6: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_valid && (rsp_exc == EXC_PROT) && rsp_code[CB_DATPROT] |-> !(rsp_wr && rsp_ex));

endmodule

// File: tb/test_lap_prefix_unit.sv
`timescale 1ns/1ps
module test_lap_prefix_unit;

  localparam int AW        = 32;
  localparam int PAGE_BITS = 12;
  localparam int AREA_BITS = 13;
  localparam int MEM_PAGES = 256;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    req_valid = 1'b0;
  logic                    req_ready;
  logic [AW-1:0]           req_addr = '0;
  logic [1:0]              req_acc = '0;
  logic [1:0]              req_mode = '0;
  logic                    lap_en = 1'b0;
  logic                    dat_on = 1'b0;
  logic                    priv_primary = 1'b0;
  logic                    priv_secondary = 1'b0;
  logic                    priv_home = 1'b0;
  logic [AW-PAGE_BITS-1:0] xlat_page = '0;
  logic                    xlat_wr_ok = 1'b1;
  logic                    xlat_ex_ok = 1'b1;
  logic [AW-AREA_BITS-1:0] pfx_base = '0;
  logic                    rsp_valid;
  logic                    rsp_ready = 1'b1;
  logic [AW-1:0]           rsp_abs;
  logic                    rsp_rd, rsp_wr, rsp_ex, rsp_wr_inv;
  logic [AW-1:0]           rsp_code;
  logic [1:0]              rsp_exc;

  always #4 clk = ~clk;

  lap_prefix_unit #(
    .AW(AW), .PAGE_BITS(PAGE_BITS), .AREA_BITS(AREA_BITS), .MEM_PAGES(MEM_PAGES),
    .LOW_WINDOWS(2), .LOW_SPAN(512)
  ) i_lap_prefix_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_acc(req_acc), .req_mode(req_mode), .lap_en(lap_en),
    .dat_on(dat_on), .priv_primary(priv_primary), .priv_secondary(priv_secondary),
    .priv_home(priv_home), .xlat_page(xlat_page), .xlat_wr_ok(xlat_wr_ok),
    .xlat_ex_ok(xlat_ex_ok), .pfx_base(pfx_base), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_abs(rsp_abs), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
    .rsp_ex(rsp_ex), .rsp_wr_inv(rsp_wr_inv), .rsp_code(rsp_code), .rsp_exc(rsp_exc)
  );

  typedef struct {
    logic [31:0] abs_a;
    logic [3:0]  flags;
    logic [31:0] code;
    logic [1:0]  exc;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_tests = 0;
  int   n_fail  = 0;

  // Configuration applied with each request.
  logic        c_en = 0, c_dat = 0, c_pp = 0, c_ps = 0, c_ph = 0;
  logic        c_wok = 1, c_eok = 1;
  logic [31:0] c_xreal = 32'h0, c_pfx = 32'h0;

  function automatic logic is_low(input logic [31:0] a);
    return (a <= 32'd511) || (a >= 32'd4096 && a <= 32'd4607);
  endfunction

  function automatic exp_t model(input string tag, input logic [31:0] a,
                                 input logic [1:0] acc, input logic [1:0] mode);
    exp_t e;
    logic        priv, on, st, fe;
    logic [31:0] page, rl, p, code;
    priv = (mode == 2'd0) ? c_pp : (mode == 2'd2) ? c_ps : (mode == 2'd3) ? c_ph : 1'b0;
    on   = c_en && (!c_dat || !priv);
    st   = (acc == 2'd1);
    fe   = (acc == 2'd2);
    page = a & ~32'hFFF;
    code = page | {30'd0, mode} | (st ? 32'h400 : 32'h800);
    rl   = c_dat ? ((c_xreal & ~32'hFFF) | (a & 32'hFFF)) : a;
    p    = c_pfx & ~32'h1FFF;
    if (rl < 32'h2000)                        e.abs_a = rl + p;
    else if (rl >= p && rl < p + 32'h2000)    e.abs_a = rl - p;
    else                                      e.abs_a = rl;
    e.flags = {1'b1, !(c_dat && !c_wok), !(c_dat && !c_eok), on && is_low(page)};
    e.exc  = 2'd0;
    e.code = code;
    if (on && is_low(a) && st) begin
      e.exc = 2'd1; e.code = code | 32'h80;
    end else if (c_dat && st && !c_wok) begin
      e.exc = 2'd1; e.code = code | 32'h4;
    end else if (c_dat && fe && !c_eok) begin
      e.exc = 2'd1; e.code = code | 32'h84;
    end else if ((e.abs_a >> 12) >= MEM_PAGES) begin
      e.exc = 2'd2; e.code = 32'h0;
    end
    e.tag = tag;
    return e;
  endfunction

  task automatic send(input string tag, input logic [31:0] a,
                      input logic [1:0] acc, input logic [1:0] mode);
    exp_t e;
    e = model(tag, a, acc, mode);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr       = a;
    req_acc        = acc;
    req_mode       = mode;
    lap_en         = c_en;
    dat_on         = c_dat;
    priv_primary   = c_pp;
    priv_secondary = c_ps;
    priv_home      = c_ph;
    xlat_page      = c_xreal[31:12];
    xlat_wr_ok     = c_wok;
    xlat_ex_ok     = c_eok;
    pfx_base       = c_pfx[31:13];
    req_valid      = 1'b1;
    sb.push_back(e);
    @(negedge clk);
    req_valid      = 1'b0;
  endtask

  task automatic check(input string tag, input logic ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp_v);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Monitor: compares each handed-over response against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (sb.size() == 0) begin
          check("R9", 1'b0, "unexpected response", rsp_code, 32'h0);
        end else begin
          exp_t e;
          logic [3:0] f;
          e = sb.pop_front();
          f = {rsp_rd, rsp_wr, rsp_ex, rsp_wr_inv};
          n_tests++;
          if (rsp_abs !== e.abs_a || f !== e.flags || rsp_code !== e.code ||
              rsp_exc !== e.exc) begin
            n_fail++;
            $display("FAIL %s: abs %h/%h flags %b/%b code %h/%h exc %0d/%0d (actual/expected)",
                     e.tag, rsp_abs, e.abs_a, f, e.flags, rsp_code, e.code, rsp_exc, e.exc);
          end
        end
      end
    end
  end

  // Watchdog.
  initial begin
    #800000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", rsp_valid == 1'b0, "rsp_valid in reset", {31'd0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check("R10", rsp_valid == 1'b0, "rsp_valid after reset", {31'd0, rsp_valid}, 32'h0);
    check("R10", req_ready == 1'b1, "req_ready after reset", {31'd0, req_ready}, 32'h1);

    // R1: window edges with protection on, translation off
    c_en = 1; c_pfx = 32'h6000;
    send("R1", 32'h0000_0000, 2'd1, 2'd0);
    send("R1", 32'h0000_01FF, 2'd1, 2'd0);
    send("R1", 32'h0000_0200, 2'd1, 2'd0);
    send("R1", 32'h0000_1000, 2'd1, 2'd2);
    send("R1", 32'h0000_11FF, 2'd1, 2'd3);
    send("R1", 32'h0000_1200, 2'd1, 2'd0);
    send("R1", 32'h0000_0FFF, 2'd1, 2'd0);
    send("R1", 32'h0000_0100, 2'd0, 2'd0);
    send("R1", 32'h0000_1100, 2'd2, 2'd0);
    // R3: invalidate flag on allowed accesses, clear outside pages 0 and 1
    send("R3", 32'h0000_0800, 2'd0, 2'd0);
    send("R3", 32'h0000_2000, 2'd1, 2'd0);
    send("R3", 32'h0000_1E00, 2'd1, 2'd0);
    // R2: enable and private-space gating
    c_en = 0;
    send("R2", 32'h0000_0010, 2'd1, 2'd0);
    c_en = 1; c_dat = 1; c_xreal = 32'h0000_0000;
    c_pp = 1;
    send("R2", 32'h0000_0010, 2'd1, 2'd0);
    c_pp = 0; c_ps = 1;
    send("R2", 32'h0000_0010, 2'd1, 2'd0);
    send("R2", 32'h0000_0010, 2'd1, 2'd2);
    c_ps = 0; c_ph = 1;
    send("R2", 32'h0000_1010, 2'd1, 2'd3);
    send("R2", 32'h0000_1010, 2'd1, 2'd1);
    c_pp = 1; c_ps = 1;
    send("R2", 32'h0000_0040, 2'd1, 2'd1);
    c_pp = 0; c_ps = 0; c_ph = 0; c_dat = 0;
    // R4: prefix swap both directions and pass-through
    c_en = 0; c_pfx = 32'h6000;
    send("R4", 32'h0000_1234, 2'd0, 2'd0);
    send("R4", 32'h0000_6010, 2'd0, 2'd0);
    send("R4", 32'h0000_7FFF, 2'd0, 2'd0);
    send("R4", 32'h0000_8000, 2'd0, 2'd0);
    send("R4", 32'h0000_5FFF, 2'd0, 2'd0);
    c_pfx = 32'h0000_0000;
    send("R4", 32'h0000_1abc, 2'd0, 2'd0);
    c_dat = 1; c_pfx = 32'h4000; c_xreal = 32'h0000_5000;
    send("R4", 32'h0003_3123, 2'd0, 2'd2);
    c_xreal = 32'h0000_1000;
    send("R4", 32'h0007_7456, 2'd0, 2'd0);
    c_dat = 0;
    // R5: code composition across modes and access types
    send("R5", 32'h0001_2345, 2'd0, 2'd3);
    send("R5", 32'h0001_2345, 2'd1, 2'd2);
    send("R5", 32'h0001_2345, 2'd2, 2'd1);
    send("R5", 32'h0001_2345, 2'd3, 2'd0);
    // R6 / R8: translated permissions
    c_dat = 1; c_xreal = 32'h0003_3000; c_wok = 0; c_eok = 1;
    send("R6", 32'h0004_4010, 2'd1, 2'd0);
    c_wok = 1; c_eok = 0;
    send("R6", 32'h0004_4010, 2'd2, 2'd2);
    c_wok = 0; c_eok = 0;
    send("R8", 32'h0004_4010, 2'd0, 2'd0);
    c_en = 1;
    send("R6", 32'h0000_0020, 2'd1, 2'd0);
    c_en = 0; c_dat = 0;
    send("R6", 32'h0004_4010, 2'd1, 2'd0);
    send("R8", 32'h0004_4010, 2'd2, 2'd0);
    c_wok = 1; c_eok = 1;
    // R7: addressing range
    send("R7", 32'h000F_FFFF, 2'd0, 2'd0);
    send("R7", 32'h0010_0000, 2'd0, 2'd2);
    send("R7", 32'h0010_0000, 2'd1, 2'd0);
    c_pfx = 32'h0020_0000;
    send("R7", 32'h0000_0100, 2'd0, 2'd0);
    send("R7", 32'h0020_0100, 2'd0, 2'd0);
    c_dat = 1; c_wok = 0; c_xreal = 32'h0050_0000;
    send("R7", 32'h0000_3000, 2'd1, 2'd0);
    c_dat = 0; c_wok = 1; c_pfx = 32'h0;

    // R9: back-pressure holds the response
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    send("R9", 32'h0000_3456, 2'd1, 2'd2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      check("R9", rsp_valid == 1'b1, "rsp_valid held", {31'd0, rsp_valid}, 32'h1);
      check("R9", req_ready == 1'b0, "req_ready low", {31'd0, req_ready}, 32'h0);
      check("R9", rsp_code == 32'h0000_3402, "code held", rsp_code, 32'h0000_3402);
    end
    @(negedge clk);
    rsp_ready = 1'b1;
    send("R9", 32'h0000_4000, 2'd0, 2'd0);
    send("R9", 32'h0000_5000, 2'd2, 2'd0);

    for (int k = 0; k < 50 && sb.size() != 0; k++) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R9", sb.size() == 0, "responses outstanding", sb.size(), 32'h0);
    finish_run();
  end

endmodule